// File: doc/BRIEF.md
# SRAM Boot Image Preload Streamer

This block fills a wide on-chip SRAM with a boot image before the core is allowed to run. Image words arrive one at a time, 32 bits wide, on a valid/ready stream. The block collects eight consecutive words into one 256-bit line. It then issues a single SRAM write for that line, at an address counted in lines. While the image is being copied, a freeze output holds the core. When the number of bytes written reaches the configured image length, freeze drops and stays low.

The image length, in bytes, is a static input. The block captures it while reset is high. In the first cycle after reset it checks the length. If the length is not a whole number of 256-byte blocks, or needs more lines than the 17-bit line address can reach, the block raises a configuration error. In that case it keeps the core frozen and accepts no data. A length of zero releases freeze at once.

Top module: `preload_streamer`

## Requirements
- R1: While reset is high, and in the cycle after it, freeze_o is 1. During reset sram_we_o is 0, sram_addr_o is 0, sram_wdata_o is 0, s_ready_o is 0 and cfg_err_o is 0.
- R2: In a line write, the k-th accepted word of that line (k = 0..7) appears on sram_wdata_o bits [32*k+31 : 32*k]. The first accepted word sits in the least significant position.
- R3: The n-th line write of an image (n counted from 0) carries sram_addr_o = n. The address grows by exactly one from one write to the next.
- R4: sram_we_o is high for exactly one cycle per completed group of eight accepted words, and in no other cycle. A valid image of L bytes produces exactly L/32 writes.
- R5: s_ready_o is low in every cycle in which sram_we_o is high, after the image is complete, and while a configuration error is flagged.
- R6: freeze_o falls in the cycle after the last line write. It then stays low until the next reset, with no further writes even if the stream keeps offering data.
- R7: A length of zero gives freeze_o low from the first cycle after reset release, with no writes.
- R8: A length that is not a multiple of 256 sets cfg_err_o from the first cycle after reset release. freeze_o stays high and no write occurs.
- R9: A length that is a multiple of 256 but needs more than 2^17 lines (more than 4 MiB) also sets cfg_err_o, keeps freeze_o high and writes nothing.
- R10: img_len_i is used only as captured during reset. Changing it after reset release has no effect on the number of writes or on the freeze release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; img_len_i is captured while it is high |
| img_len_i | input | 24 | Image length in bytes |
| s_valid_i | input | 1 | Stream word valid |
| s_data_i | input | 32 | Stream word |
| s_ready_o | output | 1 | Stream ready; a word moves when valid and ready are both high at a clock edge |
| sram_we_o | output | 1 | SRAM line write strobe |
| sram_addr_o | output | 17 | SRAM line address |
| sram_wdata_o | output | 256 | Packed 256-bit line |
| freeze_o | output | 1 | Holds the core while high |
| cfg_err_o | output | 1 | Image length rejected |

## Verification
The hardest behaviour to reach is the exact release edge. It depends on the eighth word of the final line landing while the source is stalling and then resuming. Each image length is therefore run under several valid patterns, both dense and gapped. The bench tracks accepted words itself and predicts the release cycle from the observed final write. The oversize-length fault cannot be reached by streaming a real 4 MiB image. It is instead provoked through the captured length alone, and the bench confirms that no write and no ready ever follow it.

// File: rtl/preload_pkg.sv
package preload_pkg;

    typedef enum logic [2:0] {
        ST_CHECK = 3'd0,
        ST_LOAD  = 3'd1,
        ST_WRITE = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } ld_state_e;

    typedef struct packed {
        logic fault;
        logic empty;
    } len_verdict_t;

    // Judge a captured byte length against block granularity and address reach.
    function automatic len_verdict_t judge_length(
        input logic [63:0] len_bytes,
        input logic [63:0] blk_bytes,
        input logic [63:0] line_bytes,
        input logic [63:0] max_lines
    );
        len_verdict_t v;
        v.fault = ((len_bytes % blk_bytes) != 64'd0) ||
                  ((len_bytes / line_bytes) > max_lines);
        v.empty = (len_bytes == 64'd0);
        return v;
    endfunction

endpackage

// File: rtl/preload_line_packer.sv
module preload_line_packer #(
    parameter int WORD_W         = 32,
    parameter int WORDS_PER_LINE = 8,
    localparam int LINE_W        = WORD_W * WORDS_PER_LINE,
    localparam int IDX_W         = (WORDS_PER_LINE > 1) ? $clog2(WORDS_PER_LINE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] word,
    output logic [LINE_W-1:0] line,
    output logic              line_full
);
    logic [IDX_W-1:0] slot_q;
    logic             at_last;

    assign at_last   = (slot_q == IDX_W'(WORDS_PER_LINE - 1));
    assign line_full = push && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (push) begin
            slot_q <= at_last ? '0 : slot_q + IDX_W'(1);
        end
    end

    for (genvar g = 0; g < WORDS_PER_LINE; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                line[g*WORD_W +: WORD_W] <= '0;
            end else if (push && (slot_q == IDX_W'(g))) begin
                line[g*WORD_W +: WORD_W] <= word;
            end
        end
    end
endmodule

// File: rtl/preload_sequencer.sv
module preload_sequencer
    import preload_pkg::*;
#(
    parameter int LEN_W       = 24,
    parameter int ADDR_W      = 17,
    parameter int LINE_BYTES  = 32,
    parameter int BLOCK_BYTES = 256,
    localparam int LINE_SHIFT = $clog2(LINE_BYTES),
    localparam int CNT_W      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              line_full,
    output logic              ready,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic              freeze,
    output logic              cfg_err
);
    ld_state_e      state_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] end_lines;
    logic             final_line;
    len_verdict_t   verdict;

    assign end_lines  = len_q >> LINE_SHIFT;
    assign final_line = ((LEN_W'(cnt_q) + LEN_W'(1)) == end_lines);
    assign verdict    = judge_length(64'(len_q), 64'(BLOCK_BYTES),
                                     64'(LINE_BYTES), 64'(1) << ADDR_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CHECK;
            len_q   <= len_i;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_CHECK: begin
                    if (verdict.fault)      state_q <= ST_FAULT;
                    else if (verdict.empty) state_q <= ST_DONE;
                    else                    state_q <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (line_full) state_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    cnt_q   <= cnt_q + CNT_W'(1);
                    state_q <= final_line ? ST_DONE : ST_LOAD;
                end
                ST_DONE:  state_q <= ST_DONE;
                ST_FAULT: state_q <= ST_FAULT;
                default:  state_q <= ST_FAULT;
            endcase
        end
    end

    assign ready   = (state_q == ST_LOAD);
    assign we      = (state_q == ST_WRITE);
    assign addr    = cnt_q[ADDR_W-1:0];
    assign freeze  = (state_q != ST_DONE);
    assign cfg_err = (state_q == ST_FAULT);
endmodule

// File: rtl/preload_streamer.sv
module preload_streamer #(
    parameter int WORD_W         = 32,
    parameter int WORDS_PER_LINE = 8,
    parameter int ADDR_W         = 17,
    parameter int LEN_W          = 24,
    parameter int BLOCK_BYTES    = 256,
    localparam int LINE_W        = WORD_W * WORDS_PER_LINE,
    localparam int LINE_BYTES    = LINE_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  img_len_i,
    input  logic              s_valid_i,
    input  logic [WORD_W-1:0] s_data_i,
    output logic              s_ready_o,
    output logic              sram_we_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic [LINE_W-1:0] sram_wdata_o,
    output logic              freeze_o,
    output logic              cfg_err_o
);
    logic push;
    logic line_full;

    assign push = s_valid_i && s_ready_o;

    preload_line_packer #(
        .WORD_W         (WORD_W),
        .WORDS_PER_LINE (WORDS_PER_LINE)
    ) u_packer (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .word      (s_data_i),
        .line      (sram_wdata_o),
        .line_full (line_full)
    );

    preload_sequencer #(
        .LEN_W       (LEN_W),
        .ADDR_W      (ADDR_W),
        .LINE_BYTES  (LINE_BYTES),
        .BLOCK_BYTES (BLOCK_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .len_i     (img_len_i),
        .line_full (line_full),
        .ready     (s_ready_o),
        .we        (sram_we_o),
        .addr      (sram_addr_o),
        .freeze    (freeze_o),
        .cfg_err   (cfg_err_o)
    );
endmodule

// File: rtl/preload_streamer_chk.sv
module preload_streamer_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              s_ready_o,
    input logic              sram_we_o,
    input logic [ADDR_W-1:0] sram_addr_o,
    input logic              freeze_o,
    input logic              cfg_err_o
);
    // R5
    we_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        sram_we_o |-> !s_ready_o);
    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sram_we_o |=> !sram_we_o);
    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        sram_we_o |=> (sram_addr_o == $past(sram_addr_o) + ADDR_W'(1)));
    // R6
    release_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !freeze_o |=> !freeze_o);
    // R6
    quiet_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        !freeze_o |-> (!sram_we_o && !s_ready_o));
    // R8
    fault_holds_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |-> (freeze_o && !sram_we_o && !s_ready_o));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (freeze_o && !sram_we_o && !cfg_err_o));
endmodule

bind preload_streamer preload_streamer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .s_ready_o   (s_ready_o),
    .sram_we_o   (sram_we_o),
    .sram_addr_o (sram_addr_o),
    .freeze_o    (freeze_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/test_preload_streamer.sv
`timescale 1ns/1ps
module test_preload_streamer;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [23:0]  img_len = '0;
    logic         s_valid = 1'b0;
    logic [31:0]  s_data = '0;
    logic         s_ready;
    logic         we;
    logic [16:0]  addr;
    logic [255:0] wdata;
    logic         freeze;
    logic         cfg_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    preload_streamer i_preload_streamer (
        .clk          (clk),
        .rst          (rst),
        .img_len_i    (img_len),
        .s_valid_i    (s_valid),
        .s_data_i     (s_data),
        .s_ready_o    (s_ready),
        .sram_we_o    (we),
        .sram_addr_o  (addr),
        .sram_wdata_o (wdata),
        .freeze_o     (freeze),
        .cfg_err_o    (cfg_err)
    );

    function automatic logic [31:0] word_val(input int k);
        return (32'h9E37_79B9 * 32'(k + 1)) ^ 32'(k);
    endfunction

    function automatic logic [255:0] line_val(input int n);
        logic [255:0] l;
        for (int i = 0; i < 8; i++) l[32*i +: 32] = word_val(n * 8 + i);
        return l;
    endfunction

    function automatic bit offer(input int pat, input int c);
        case (pat)
            0:       return 1'b1;
            1:       return (c % 3) != 1;
            default: return ((c * 5) % 7) < 3;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_case(input int len, input int pat, input bit move_len);
        bit cfg_ok = ((len % 256) == 0) && ((len / 32) <= (1 << 17));
        int nlines = cfg_ok ? len / 32 : 0;
        int seen = 0;
        int words = 0;
        int due = 1 << 30;
        int limit = (len / 32) * 8 * 3 + 40;
        if (!cfg_ok) limit = 40;
        if (cfg_ok && nlines == 0) due = 1;
        @(negedge clk);
        rst = 1'b1; s_valid = 1'b0; img_len = 24'(len);
        @(negedge clk); @(negedge clk);
        // R1
        check(freeze && !we && addr == 0 && wdata == 0 && !s_ready && !cfg_err,
              "R1 reset state", {freeze, we, s_ready, cfg_err, 17'(addr)}, 21'h100000);
        rst = 1'b0;
        // R10: length moves after capture
        if (move_len) img_len = 24'(len + 256);
        // R1: still frozen right after release
        check(freeze, "R1 freeze after release", 256'(freeze), 256'd1);
        for (int c = 1; c <= limit; c++) begin
            @(negedge clk);
            if (we) begin
                // R5
                check(!s_ready, "R5 ready low during write", 256'(s_ready), 256'd0);
                // R3
                check(addr == 17'(seen), "R3 line address", 256'(addr), 256'(seen));
                // R2
                check(wdata == line_val(seen), "R2 packing", wdata, line_val(seen));
                // R4
                check(seen < nlines, "R4 no extra write", 256'(seen), 256'(nlines));
                seen++;
                if (seen == nlines) due = c + 1;
            end
            // R6 R7
            check(freeze == !(cfg_ok && c >= due), "R6 R7 freeze timing",
                  256'(freeze), 256'(!(cfg_ok && c >= due)));
            // R8 R9
            check(cfg_err == !cfg_ok, "R8 R9 error flag", 256'(cfg_err), 256'(!cfg_ok));
            if (!freeze || cfg_err)
                check(!s_ready, "R5 ready low when idle", 256'(s_ready), 256'd0);
            s_valid = offer(pat, c);
            s_data  = word_val(words);
            if (s_valid && s_ready) words++;
        end
        s_valid = 1'b0;
        // R4 R10
        check(seen == nlines, "R4 R10 write count", 256'(seen), 256'(nlines));
    endtask

    initial begin
        run_case(0, 0, 1'b0);
        run_case(256, 0, 1'b0);
        run_case(256, 1, 1'b0);
        run_case(512, 2, 1'b0);
        run_case(768, 1, 1'b0);
        run_case(1024, 2, 1'b0);
        run_case(256, 2, 1'b1);
        run_case(100, 0, 1'b0);
        run_case(288, 1, 1'b0);
        run_case(4194304 + 256, 0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule